// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Write-Back or Write-Through

This block sits between a processor request port and a slower main-memory port. Addresses are byte addresses, and each addressable word is one byte. Memory is moved in blocks of several bytes. Every address is split into three fields, from the top bit down: a tag, a line index and a byte offset. The line index picks exactly one cache line. That line's valid bit and stored tag decide whether the access hits.

On a hit, the byte is read from the line or merged into it, and the processor gets its response one cycle after the request is accepted. On a miss, the controller first fetches the whole block from memory into the indexed line, then serves the request from the cache. In write-back mode, writes touch only the line and mark it dirty. A dirty line that is about to be replaced is first written to memory with its old address. In write-through mode, which is chosen by a parameter, every write also sends the updated block to memory, and a line is never dirty.

The processor side is a valid/ready request channel with a response strobe. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle, so the processor applies back-pressure simply by holding its request. The response is a single-cycle `rsp_valid` pulse. It has no ready signal: the processor must always accept it. The memory side is a request/acknowledge handshake. The controller raises `mem_valid` and holds address, direction and write data steady until `mem_ready` is high for one cycle. For a read, `mem_rdata` is valid in that same cycle.

Top module: `dmc_cache`

## Requirements
- R1: Field split. With the defaults (24-bit address, 10-bit index, 2-bit offset), the tag is bits 23:12, the index is bits 11:2 and the offset is bits 1:0. All bytes of one block share a line. Blocks with equal index but different tag compete for the same line.
- R2: After reset, `req_ready` is 1, and `rsp_valid` and `mem_valid` are 0. Reset invalidates every line, so the first access to any address afterwards is a miss.
- R3: A hit that needs no memory traffic raises `rsp_valid` in the cycle right after acceptance. For a read, `rsp_rdata` is the byte at offset k, taken from bits 8k+7:8k of the block.
- R4: A miss keeps `req_ready` low until the refill (and any write-back) has finished. The refill is one memory read of the block address {tag, index}. The response then carries the byte now held in the line.
- R5: In write-back mode, a write hit causes no memory transfer and responds after one cycle. A later read of that byte returns the written value.
- R6: In write-back mode, when a dirty line is replaced, its block is written to memory at {old tag, index} before the refill read. This is exactly one memory write, and the written byte can later be read back through the cache.
- R7: Replacing a clean line causes no memory write.
- R8: In write-through mode, every write, hit or miss, causes exactly one memory write of the updated block, and memory then holds the new byte. Evictions never write.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stay unchanged.
- R10: A write miss fills the block from memory and then merges the written byte. The other bytes of the block keep their memory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read (0 for writes) |
| mem_valid | output | 1 | Memory transfer requested |
| mem_ready | input | 1 | Memory acknowledge, one cycle |
| mem_write | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 22 | Block address {tag, index} |
| mem_wdata | output | 32 | Block written to memory |
| mem_rdata | input | 32 | Block returned on a read acknowledge |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- **Conflicting blocks on one line.** It alternates between blocks that share an index. A wrong tag or index split would then either report false hits with stale bytes, or miss on bytes of a block that was just filled.
- **Dirty versus clean victims.** It counts memory writes during each access. A design that skips the write-back loses a written byte. One that writes back clean lines shows an extra memory write.
- **Write miss.** A write miss followed by reads of neighbouring bytes catches a design that merges before the refill, or that overwrites the whole block.
- **Write-through mode.** In this mode, a design that leaves memory stale shows up as a missing memory write.
- **Reset.** Re-reset followed by an access to a line that was resident must miss. A design that does not invalidate on reset would return the access in one cycle.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EVICT  = 3'd1,
    ST_FILL   = 3'd2,
    ST_REPLAY = 3'd3,
    ST_PUSH   = 3'd4
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 10,
  parameter int OFS_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFS_W-1:0]  ofs
);
  // tag | index | offset, most significant first
  assign tag = addr[ADDR_W-1 -: TAG_W];
  assign idx = addr[OFS_W +: IDX_W];
  assign ofs = addr[OFS_W-1:0];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 12,
  parameter int OFS_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       idx,
  output logic [(8<<OFS_W)-1:0]  rd_data,
  output logic [TAG_W-1:0]       rd_tag,
  output logic                   rd_valid,
  output logic                   rd_dirty,
  input  logic                   fill_en,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic [(8<<OFS_W)-1:0]  fill_data,
  input  logic                   byte_en,
  input  logic [OFS_W-1:0]       byte_ofs,
  input  logic [7:0]             byte_data,
  input  logic                   set_dirty
);
  localparam int LINES = 1 << IDX_W;
  localparam int BLK_W = 8 << OFS_W;

  logic [BLK_W-1:0] data_q [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [BLK_W-1:0] merged;

  assign rd_data  = data_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  always_comb begin
    merged = data_q[idx];
    merged[{byte_ofs, 3'b000} +: 8] = byte_data;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[idx] <= fill_data;
      tag_q[idx]  <= fill_tag;
    end else if (byte_en) begin
      data_q[idx] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (byte_en && set_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  a_r2_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(idx)]);
  a_r4_fill_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !dirty_q[$past(idx)]);
  a_r5_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && set_dirty) |=> dirty_q[$past(idx)]);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 10,
  parameter int OFS_W      = 2,
  parameter int TAG_W      = ADDR_W - IDX_W - OFS_W,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [7:0]                req_wdata,
  output logic                      rsp_valid,
  output logic [7:0]                rsp_rdata,
  output logic [ADDR_W-1:0]         act_addr,
  input  logic [TAG_W-1:0]          act_tag,
  input  logic [IDX_W-1:0]          act_idx,
  input  logic [OFS_W-1:0]          act_ofs,
  input  logic [(8<<OFS_W)-1:0]     line_data,
  input  logic [TAG_W-1:0]          line_tag,
  input  logic                      line_valid,
  input  logic                      line_dirty,
  output logic                      fill_en,
  output logic [(8<<OFS_W)-1:0]     fill_data,
  output logic                      byte_en,
  output logic [7:0]                byte_data,
  output logic                      set_dirty,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_write,
  output logic [ADDR_W-OFS_W-1:0]   mem_addr,
  output logic [(8<<OFS_W)-1:0]     mem_wdata,
  input  logic [(8<<OFS_W)-1:0]     mem_rdata
);
  dmc_state_e state_q, state_d;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_wdata;
  logic              idle, act_write, go, hit, done;
  logic [7:0]        act_wdata;

  assign idle      = (state_q == ST_IDLE);
  assign act_addr  = idle ? req_addr  : lat_addr;
  assign act_write = idle ? req_write : lat_write;
  assign act_wdata = idle ? req_wdata : lat_wdata;
  assign hit       = line_valid && (line_tag == act_tag);
  assign go        = (idle && req_valid) || (state_q == ST_REPLAY);
  assign req_ready = idle;

  assign byte_en   = go && hit && act_write;
  assign byte_data = act_wdata;
  assign set_dirty = WRITE_BACK;
  assign fill_en   = (state_q == ST_FILL) && mem_ready;
  assign fill_data = mem_rdata;

  assign mem_valid = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_PUSH);
  assign mem_write = (state_q != ST_FILL);
  assign mem_addr  = (state_q == ST_EVICT) ? {line_tag, act_idx} : {act_tag, act_idx};
  assign mem_wdata = line_data;

  assign done = (go && hit && (!act_write || WRITE_BACK)) ||
                ((state_q == ST_PUSH) && mem_ready);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (hit) state_d = (req_write && !WRITE_BACK) ? ST_PUSH : ST_IDLE;
          else     state_d = (WRITE_BACK && line_valid && line_dirty) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT:  if (mem_ready) state_d = ST_FILL;
      ST_FILL:   if (mem_ready) state_d = ST_REPLAY;
      ST_REPLAY: state_d = (lat_write && !WRITE_BACK) ? ST_PUSH : ST_IDLE;
      ST_PUSH:   if (mem_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q <= state_d;
      if (idle && req_valid) begin
        lat_write <= req_write;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      rsp_valid <= done;
      rsp_rdata <= (done && !act_write) ? line_data[{act_ofs, 3'b000} +: 8] : 8'h00;
    end
  end

  a_r3_hit_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_valid && hit && !req_write) |=> rsp_valid);
  a_r4_busy_blocks_requests: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  a_r4_replay_after_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REPLAY) |-> hit);
  a_r6_evict_then_refill: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EVICT) && mem_ready) |=> (mem_valid && !mem_write));
  a_r8_through_never_evicts: assert property (@(posedge clk) disable iff (!rst_n)
    !WRITE_BACK |-> (state_q != ST_EVICT));
  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 10,
  parameter int OFS_W      = 2,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [7:0]                      req_wdata,
  output logic                            rsp_valid,
  output logic [7:0]                      rsp_rdata,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic                            mem_write,
  output logic [ADDR_W-OFS_W-1:0]         mem_addr,
  output logic [(8<<OFS_W)-1:0]           mem_wdata,
  input  logic [(8<<OFS_W)-1:0]           mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int BLK_W = 8 << OFS_W;

  logic [ADDR_W-1:0] act_addr;
  logic [TAG_W-1:0]  act_tag, line_tag;
  logic [IDX_W-1:0]  act_idx;
  logic [OFS_W-1:0]  act_ofs;
  logic [BLK_W-1:0]  line_data, fill_data;
  logic              line_valid, line_dirty, fill_en, byte_en, set_dirty;
  logic [7:0]        byte_data;

  dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .TAG_W(TAG_W)) u_split (
    .addr(act_addr), .tag(act_tag), .idx(act_idx), .ofs(act_ofs)
  );

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFS_W(OFS_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(act_idx),
    .rd_data(line_data), .rd_tag(line_tag), .rd_valid(line_valid), .rd_dirty(line_dirty),
    .fill_en(fill_en), .fill_tag(act_tag), .fill_data(fill_data),
    .byte_en(byte_en), .byte_ofs(act_ofs), .byte_data(byte_data), .set_dirty(set_dirty)
  );

  dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W), .TAG_W(TAG_W),
             .WRITE_BACK(WRITE_BACK)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .act_addr(act_addr), .act_tag(act_tag), .act_idx(act_idx), .act_ofs(act_ofs),
    .line_data(line_data), .line_tag(line_tag), .line_valid(line_valid), .line_dirty(line_dirty),
    .fill_en(fill_en), .fill_data(fill_data),
    .byte_en(byte_en), .byte_data(byte_data), .set_dirty(set_dirty),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/1ps
module dmc_mem_model #(
  parameter int AW  = 22,
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_valid,
  input  logic          mem_write,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic          mem_ready,
  output logic [DW-1:0] mem_rdata
);
  logic [DW-1:0] store [4096];
  int wr_count = 0;
  int rd_count = 0;
  int hold_err = 0;
  int cnt = 0;
  logic pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;

  initial begin
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] x;
      x = i;
      store[i] = (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    end
    mem_ready = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      cnt <= 0;
      pend <= 1'b0;
    end else begin
      mem_ready <= 1'b0;
      pend <= mem_valid && !mem_ready;
      pend_addr <= mem_addr;
      if (pend && mem_valid && mem_addr != pend_addr) hold_err <= hold_err + 1;
      if (mem_valid && !mem_ready) begin
        if (cnt == LAT) begin
          cnt <= 0;
          mem_ready <= 1'b1;
          mem_rdata <= store[mem_addr[11:0]];
          if (mem_write) begin
            store[mem_addr[11:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
          end else begin
            rd_count <= rd_count + 1;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end
endmodule

module dmc_cache_tb;
  typedef struct packed {
    logic        we;
    logic [23:0] addr;
    logic [7:0]  wd;
    logic        hit;
    logic [1:0]  nwr;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 24'h000004, 8'h00, 1'b0, 2'd0},
    '{1'b0, 24'h000005, 8'h00, 1'b1, 2'd0},
    '{1'b1, 24'h000006, 8'hA5, 1'b1, 2'd0},
    '{1'b0, 24'h000006, 8'h00, 1'b1, 2'd0},
    '{1'b0, 24'h001004, 8'h00, 1'b0, 2'd1},
    '{1'b0, 24'h000006, 8'h00, 1'b0, 2'd0},
    '{1'b1, 24'h002008, 8'h3C, 1'b0, 2'd0},
    '{1'b0, 24'h002009, 8'h00, 1'b1, 2'd0},
    '{1'b0, 24'h002008, 8'h00, 1'b1, 2'd0},
    '{1'b0, 24'h003FFC, 8'h00, 1'b0, 2'd0},
    '{1'b1, 24'h003FFF, 8'h77, 1'b1, 2'd0},
    '{1'b0, 24'h000FFC, 8'h00, 1'b0, 2'd1},
    '{1'b0, 24'h003FFF, 8'h00, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic rdy_wb, rdy_wt, rv_wb, rv_wt;
  logic [7:0] rd_wb, rd_wt;
  logic mv_wb, mr_wb, mw_wb, mv_wt, mr_wt, mw_wt;
  logic [21:0] ma_wb, ma_wt;
  logic [31:0] mwd_wb, mrd_wb, mwd_wt, mrd_wt;
  logic req_ready, rsp_valid, mem_valid;
  logic [7:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] ref_wb [4096];

  always #10 clk = ~clk;

  dmc_cache #(.WRITE_BACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel), .req_ready(rdy_wb),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_wb), .rsp_rdata(rd_wb),
    .mem_valid(mv_wb), .mem_ready(mr_wb), .mem_write(mw_wb), .mem_addr(ma_wb),
    .mem_wdata(mwd_wb), .mem_rdata(mrd_wb)
  );
  dmc_mem_model u_mem_wb (
    .clk(clk), .rst_n(rst_n), .mem_valid(mv_wb), .mem_write(mw_wb), .mem_addr(ma_wb),
    .mem_wdata(mwd_wb), .mem_ready(mr_wb), .mem_rdata(mrd_wb)
  );

  dmc_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel), .req_ready(rdy_wt),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rv_wt), .rsp_rdata(rd_wt),
    .mem_valid(mv_wt), .mem_ready(mr_wt), .mem_write(mw_wt), .mem_addr(ma_wt),
    .mem_wdata(mwd_wt), .mem_rdata(mrd_wt)
  );
  dmc_mem_model u_mem_wt (
    .clk(clk), .rst_n(rst_n), .mem_valid(mv_wt), .mem_write(mw_wt), .mem_addr(ma_wt),
    .mem_wdata(mwd_wt), .mem_ready(mr_wt), .mem_rdata(mrd_wt)
  );

  assign req_ready = sel ? rdy_wt : rdy_wb;
  assign rsp_valid = sel ? rv_wt  : rv_wb;
  assign rsp_rdata = sel ? rd_wt  : rd_wb;
  assign mem_valid = sel ? mv_wt  : mv_wb;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [23:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat, output int busy_err);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_err = 0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) busy_err++;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  function automatic logic [7:0] ref_byte(input logic [23:0] a);
    logic [31:0] w;
    w = ref_wb[a[13:2]];
    return w[{a[1:0], 3'b000} +: 8];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat, busy, wr0, rd0;
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] x;
      x = i;
      ref_wb[i] = (x * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state at the ports
    chk(req_ready == 1'b1, "R2", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R2", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_valid == 1'b0, "R2", "mem_valid after reset", mem_valid, 0);
    rst_n = 1'b1;

    // Vector walk on the write-back instance
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] exp_rd;
      wr0 = u_mem_wb.wr_count;
      do_op(VEC[i].we, VEC[i].addr, VEC[i].wd, rd, lat, busy);
      if (VEC[i].we) begin
        ref_wb[VEC[i].addr[13:2]][{VEC[i].addr[1:0], 3'b000} +: 8] = VEC[i].wd;
        exp_rd = 8'h00;
      end else begin
        exp_rd = ref_byte(VEC[i].addr);
      end
      // R1 R2 R3: hit means response one cycle after acceptance
      chk((lat == 1) == VEC[i].hit, "R1 R3", $sformatf("vec %0d latency", i), lat, VEC[i].hit ? 1 : 2);
      // R3 R4 R10: returned byte
      chk(rd == exp_rd, "R3 R4 R10", $sformatf("vec %0d rdata", i), rd, exp_rd);
      // R5 R6 R7: memory writes during the access
      chk(u_mem_wb.wr_count - wr0 == int'(VEC[i].nwr), "R5 R6 R7",
          $sformatf("vec %0d mem writes", i), u_mem_wb.wr_count - wr0, VEC[i].nwr);
      // R4: no acceptance while busy
      chk(busy == 0, "R4", $sformatf("vec %0d ready while busy", i), busy, 0);
    end
    // R6: evicted dirty block reached memory at its old address
    chk(u_mem_wb.store[12'h001][23:16] == 8'hA5, "R6", "written-back byte in memory",
        u_mem_wb.store[12'h001][23:16], 8'hA5);

    // R2: reset invalidates lines
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    do_op(1'b0, 24'h003FFF, 8'h00, rd, lat, busy);
    chk(lat > 1, "R2", "access after reset misses", lat, 2);
    chk(rd == 8'h77, "R2", "data after reset refill", rd, 8'h77);

    // Write-through instance
    sel = 1'b1;
    wr0 = u_mem_wt.wr_count; rd0 = u_mem_wt.rd_count;
    do_op(1'b1, 24'h000104, 8'h11, rd, lat, busy);
    chk(u_mem_wt.wr_count - wr0 == 1, "R8", "write miss mem writes", u_mem_wt.wr_count - wr0, 1);
    chk(u_mem_wt.rd_count - rd0 == 1, "R4", "write miss refill reads", u_mem_wt.rd_count - rd0, 1);
    chk(u_mem_wt.store[12'h041][7:0] == 8'h11, "R8", "memory byte after write miss",
        u_mem_wt.store[12'h041][7:0], 8'h11);
    wr0 = u_mem_wt.wr_count;
    do_op(1'b1, 24'h000105, 8'h22, rd, lat, busy);
    chk(u_mem_wt.wr_count - wr0 == 1, "R8", "write hit mem writes", u_mem_wt.wr_count - wr0, 1);
    chk(u_mem_wt.store[12'h041][15:8] == 8'h22, "R8", "memory byte after write hit",
        u_mem_wt.store[12'h041][15:8], 8'h22);
    do_op(1'b0, 24'h000104, 8'h00, rd, lat, busy);
    chk(lat == 1, "R3", "write-through read hit latency", lat, 1);
    chk(rd == 8'h11, "R3", "write-through read hit data", rd, 8'h11);
    wr0 = u_mem_wt.wr_count;
    do_op(1'b0, 24'h001104, 8'h00, rd, lat, busy);
    chk(u_mem_wt.wr_count - wr0 == 0, "R7 R8", "eviction writes in write-through",
        u_mem_wt.wr_count - wr0, 0);
    do_op(1'b0, 24'h000105, 8'h00, rd, lat, busy);
    chk(lat > 1, "R1", "conflicting block evicted", lat, 2);
    chk(rd == 8'h22, "R8", "byte reread from memory", rd, 8'h22);

    // R9: handshake stability seen by both memory models
    chk(u_mem_wb.hold_err == 0, "R9", "write-back port request changed", u_mem_wb.hold_err, 0);
    chk(u_mem_wt.hold_err == 0, "R9", "write-through port request changed", u_mem_wt.hold_err, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule